// File: doc/BRIEF.md
# DSP Parallel Bus Move Unit

This block is the register-transfer stage of a small signal-processing datapath. Each cycle it takes up to three decoded move fields, one for each of three buses, and carries them out together. The X bus feeds the multiplier operand register RX and the product register (PH:PL). The Y bus feeds the second operand register RY and the accumulator (ACH:ACL). The D1 bus is a general path. It can write a sign-extended short immediate, or copy any data RAM bank or register, into any data RAM bank or register.

A separate load-immediate instruction (MVI) writes a full-width immediate to a D1-style destination. It can be made conditional on the zero flag. While MVI is active, all three bus fields are ignored. The ALU and the multiplier lie outside the block; only their results come in as inputs. Data RAM writes leave as one-hot strobes with a shared data word.

Top module: `pbus_move_unit`

## Requirements
- R1: While reset is active and after it is released, RX, RY, PH, PL, ACH and ACL read zero and no data RAM write strobe is raised.
- R2: With x_op=0, y_op=0, d1_op=0 and mvi_en low, every register keeps its value and no RAM strobe is raised.
- R3: x_op=1 loads RX from RAM bank x_src. x_op=3 loads PL from bank x_src and leaves PH unchanged. x_op=2 loads PH with mul_prod[47:32] and PL with mul_prod[31:0].
- R4: y_op=1 loads RY from bank y_src. y_op=2 clears ACH and ACL. y_op=3 loads ACH with alu_res[47:32] and ACL with alu_res[31:0]. y_op=4 loads ACL from bank y_src and leaves ACH unchanged. The codes 0 and 5 to 7 change nothing.
- R5: d1_op=1 writes d1_simm, sign-extended from 8 to 32 bits, to destination d1_dst. Codes 0 to 3 select RAM banks 0 to 3, 4 selects RX, 5 RY, 6 PL and 7 ACL.
- R6: d1_op=2 copies source d1_src to d1_dst. The source uses the same code map as R5 (0 to 3 RAM bank, 4 RX, 5 RY, 6 PL, 7 ACL). d1_op=3 does nothing.
- R7: Every move reads its source as it stood before the cycle's edge, so moves in the same cycle never pass data to each other.
- R8: When D1 (or MVI) and an X or Y move target the same register in one cycle, the D1 value is stored. A PL write from D1 leaves a concurrent PH load from the product intact.
- R9: mvi_en with mvi_cond=0 writes mvi_imm to mvi_dst, using the R5 code map.
- R10: mvi_cond=1 writes only when zero_flag is 1, mvi_cond=2 only when zero_flag is 0, and mvi_cond=3 never. A failed condition changes no register and raises no strobe.
- R11: While mvi_en is high, x_op, y_op and d1_op have no effect.
- R12: ram_we is one-hot or zero. It is driven in the same cycle as the move, with ram_wdata, and register results appear after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| x_op | input | 2 | X bus move code |
| x_src | input | 2 | X bus RAM bank select |
| y_op | input | 3 | Y bus move code |
| y_src | input | 2 | Y bus RAM bank select |
| d1_op | input | 2 | D1 bus move code |
| d1_src | input | 3 | D1 source code |
| d1_dst | input | 3 | D1 destination code |
| d1_simm | input | 8 | D1 short immediate |
| mvi_en | input | 1 | Load-immediate instruction active |
| mvi_cond | input | 2 | Load-immediate condition |
| mvi_dst | input | 3 | Load-immediate destination code |
| mvi_imm | input | 32 | Load-immediate value |
| zero_flag | input | 1 | Zero flag from the program controller |
| ram_rdata | input | 128 | Read data of the four RAM banks, bank b at [32b+31:32b] |
| mul_prod | input | 48 | Multiplier product |
| alu_res | input | 48 | ALU result |
| rx_q | output | 32 | RX register |
| ry_q | output | 32 | RY register |
| ph_q | output | 16 | Product high register |
| pl_q | output | 32 | Product low register |
| ach_q | output | 16 | Accumulator high register |
| acl_q | output | 32 | Accumulator low register |
| ram_we | output | 4 | One-hot RAM bank write strobe |
| ram_wdata | output | 32 | RAM write data |

## Verification
The RAM strobe and write data are combinational, so they are due in the same cycle the fields are applied. The bench reads them one time unit after driving, before the rising edge. Register results are due one edge later. The bench reads them one time unit after that edge and compares them with a reference state it advances by the rules above. Reset values are read only after the two-flop reset release has finished.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [1:0] {XB_NOP = 2'd0, XB_RX = 2'd1, XB_MUL = 2'd2, XB_PL = 2'd3} xbus_op_e;
  typedef enum logic [2:0] {YB_NOP = 3'd0, YB_RY = 3'd1, YB_CLR = 3'd2, YB_ALU = 3'd3,
                            YB_ACL = 3'd4} ybus_op_e;
  typedef enum logic [1:0] {D1_NOP = 2'd0, D1_SIMM = 2'd1, D1_MOV = 2'd2, D1_RSV = 2'd3} d1_op_e;
  typedef enum logic [1:0] {MC_ALWAYS = 2'd0, MC_ZERO = 2'd1, MC_NZERO = 2'd2, MC_NEVER = 2'd3} mvi_cond_e;
  // register slot offsets above the RAM bank codes
  localparam int SLOT_RX  = 0;
  localparam int SLOT_RY  = 1;
  localparam int SLOT_PL  = 2;
  localparam int SLOT_ACL = 3;
  localparam int NREGSLOT = 4;
endpackage

// File: rtl/pbm_rst_sync.sv
module pbm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pbm_bank_sel.sv
module pbm_bank_sel #(
  parameter int NBANK = 4,
  parameter int DW    = 32,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic [NBANK*DW-1:0] rdata_flat,
  input  logic [BW-1:0]       sel,
  output logic [DW-1:0]       data
);
  logic [DW-1:0] bank [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_unpack
    assign bank[b] = rdata_flat[b*DW +: DW];
  end

  assign data = bank[sel];
endmodule

// File: rtl/pbm_d1_route.sv
module pbm_d1_route
  import pbm_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int DW    = 32,
  parameter int SW    = 8,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = $clog2(NBANK + NREGSLOT),
  localparam int NSLOT = 2 ** CW
) (
  input  logic [1:0]          d1_op,
  input  logic [CW-1:0]       d1_src,
  input  logic [CW-1:0]       d1_dst,
  input  logic [SW-1:0]       d1_simm,
  input  logic                mvi_en,
  input  logic [1:0]          mvi_cond,
  input  logic [CW-1:0]       mvi_dst,
  input  logic [DW-1:0]       mvi_imm,
  input  logic                zero_flag,
  input  logic [NBANK*DW-1:0] ram_rdata,
  input  logic [DW-1:0]       rx_q,
  input  logic [DW-1:0]       ry_q,
  input  logic [DW-1:0]       pl_q,
  input  logic [DW-1:0]       acl_q,
  output logic [DW-1:0]       wr_data,
  output logic [NREGSLOT-1:0] reg_we,
  output logic [NBANK-1:0]    ram_we
);
  localparam logic [CW-1:0] CODE_RX  = CW'(NBANK + SLOT_RX);
  localparam logic [CW-1:0] CODE_RY  = CW'(NBANK + SLOT_RY);
  localparam logic [CW-1:0] CODE_PL  = CW'(NBANK + SLOT_PL);
  localparam logic [CW-1:0] CODE_ACL = CW'(NBANK + SLOT_ACL);
  localparam logic [CW-1:0] CODE_RAM_TOP = CW'(NBANK);

  logic [DW-1:0]    bank_val;
  logic [DW-1:0]    src_val;
  logic             cond_ok;
  logic             wr_any;
  logic [CW-1:0]    dst_code;
  logic [NSLOT-1:0] dst_hot;

  pbm_bank_sel #(.NBANK(NBANK), .DW(DW)) u_d1_bank (
    .rdata_flat (ram_rdata),
    .sel        (d1_src[BW-1:0]),
    .data       (bank_val)
  );

  always_comb begin
    if (d1_src < CODE_RAM_TOP) src_val = bank_val;
    else begin
      unique case (d1_src)
        CODE_RX:  src_val = rx_q;
        CODE_RY:  src_val = ry_q;
        CODE_PL:  src_val = pl_q;
        CODE_ACL: src_val = acl_q;
        default:  src_val = '0;
      endcase
    end
  end

  always_comb begin
    unique case (mvi_cond_e'(mvi_cond))
      MC_ALWAYS: cond_ok = 1'b1;
      MC_ZERO:   cond_ok = zero_flag;
      MC_NZERO:  cond_ok = !zero_flag;
      default:   cond_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (mvi_en) begin
      wr_any   = cond_ok;
      wr_data  = mvi_imm;
      dst_code = mvi_dst;
    end else begin
      wr_any   = (d1_op == D1_SIMM) || (d1_op == D1_MOV);
      wr_data  = (d1_op == D1_SIMM) ? {{(DW-SW){d1_simm[SW-1]}}, d1_simm} : src_val;
      dst_code = d1_dst;
    end
  end

  assign dst_hot = wr_any ? (NSLOT'(1) << dst_code) : '0;
  assign ram_we  = dst_hot[NBANK-1:0];
  assign reg_we  = dst_hot[NBANK +: NREGSLOT];
endmodule

// File: rtl/pbus_move_unit.sv
module pbus_move_unit
  import pbm_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int DW    = 32,
  parameter int HW    = 16,
  parameter int SW    = 8,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = $clog2(NBANK + NREGSLOT),
  localparam int WW   = HW + DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          x_op,
  input  logic [BW-1:0]       x_src,
  input  logic [2:0]          y_op,
  input  logic [BW-1:0]       y_src,
  input  logic [1:0]          d1_op,
  input  logic [CW-1:0]       d1_src,
  input  logic [CW-1:0]       d1_dst,
  input  logic [SW-1:0]       d1_simm,
  input  logic                mvi_en,
  input  logic [1:0]          mvi_cond,
  input  logic [CW-1:0]       mvi_dst,
  input  logic [DW-1:0]       mvi_imm,
  input  logic                zero_flag,
  input  logic [NBANK*DW-1:0] ram_rdata,
  input  logic [WW-1:0]       mul_prod,
  input  logic [WW-1:0]       alu_res,
  output logic [DW-1:0]       rx_q,
  output logic [DW-1:0]       ry_q,
  output logic [HW-1:0]       ph_q,
  output logic [DW-1:0]       pl_q,
  output logic [HW-1:0]       ach_q,
  output logic [DW-1:0]       acl_q,
  output logic [NBANK-1:0]    ram_we,
  output logic [DW-1:0]       ram_wdata
);
  logic                rst_sync_n;
  logic [DW-1:0]       x_bank, y_bank, wr_data;
  logic [NREGSLOT-1:0] reg_we;
  logic [DW-1:0]       rx_d, ry_d, pl_d, acl_d;
  logic [HW-1:0]       ph_d, ach_d;
  logic                rx_en, ry_en, ph_en, pl_en, ach_en, acl_en;
  xbus_op_e            xop;
  ybus_op_e            yop;

  pbm_rst_sync u_rst_sync (.clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n));

  pbm_bank_sel #(.NBANK(NBANK), .DW(DW)) u_x_bank (
    .rdata_flat (ram_rdata), .sel (x_src), .data (x_bank));

  pbm_bank_sel #(.NBANK(NBANK), .DW(DW)) u_y_bank (
    .rdata_flat (ram_rdata), .sel (y_src), .data (y_bank));

  pbm_d1_route #(.NBANK(NBANK), .DW(DW), .SW(SW)) u_d1_route (
    .d1_op     (d1_op),
    .d1_src    (d1_src),
    .d1_dst    (d1_dst),
    .d1_simm   (d1_simm),
    .mvi_en    (mvi_en),
    .mvi_cond  (mvi_cond),
    .mvi_dst   (mvi_dst),
    .mvi_imm   (mvi_imm),
    .zero_flag (zero_flag),
    .ram_rdata (ram_rdata),
    .rx_q      (rx_q),
    .ry_q      (ry_q),
    .pl_q      (pl_q),
    .acl_q     (acl_q),
    .wr_data   (wr_data),
    .reg_we    (reg_we),
    .ram_we    (ram_we)
  );

  assign ram_wdata = wr_data;
  // bus fields are void while a load-immediate is active
  assign xop = mvi_en ? XB_NOP : xbus_op_e'(x_op);
  assign yop = mvi_en ? YB_NOP : ybus_op_e'(y_op);

  // next-state: X and Y first, D1 route overrides on the same register
  always_comb begin
    rx_d  = rx_q;  ry_d  = ry_q;  ph_d  = ph_q;
    pl_d  = pl_q;  ach_d = ach_q; acl_d = acl_q;
    rx_en = 1'b0;  ry_en = 1'b0;  ph_en = 1'b0;
    pl_en = 1'b0;  ach_en = 1'b0; acl_en = 1'b0;

    unique case (xop)
      XB_RX:  begin rx_d = x_bank; rx_en = 1'b1; end
      XB_MUL: begin
        ph_d = mul_prod[WW-1:DW]; pl_d = mul_prod[DW-1:0];
        ph_en = 1'b1; pl_en = 1'b1;
      end
      XB_PL:  begin pl_d = x_bank; pl_en = 1'b1; end
      default: ;
    endcase

    case (yop)
      YB_RY:  begin ry_d = y_bank; ry_en = 1'b1; end
      YB_CLR: begin ach_d = '0; acl_d = '0; ach_en = 1'b1; acl_en = 1'b1; end
      YB_ALU: begin
        ach_d = alu_res[WW-1:DW]; acl_d = alu_res[DW-1:0];
        ach_en = 1'b1; acl_en = 1'b1;
      end
      YB_ACL: begin acl_d = y_bank; acl_en = 1'b1; end
      default: ;
    endcase

    if (reg_we[SLOT_RX])  begin rx_d  = wr_data; rx_en  = 1'b1; end
    if (reg_we[SLOT_RY])  begin ry_d  = wr_data; ry_en  = 1'b1; end
    if (reg_we[SLOT_PL])  begin pl_d  = wr_data; pl_en  = 1'b1; end
    if (reg_we[SLOT_ACL]) begin acl_d = wr_data; acl_en = 1'b1; end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_q <= '0; ry_q <= '0; ph_q <= '0;
      pl_q <= '0; ach_q <= '0; acl_q <= '0;
    end else begin
      if (rx_en)  rx_q  <= rx_d;
      if (ry_en)  ry_q  <= ry_d;
      if (ph_en)  ph_q  <= ph_d;
      if (pl_en)  pl_q  <= pl_d;
      if (ach_en) ach_q <= ach_d;
      if (acl_en) acl_q <= acl_d;
    end
  end
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
  parameter int NBANK = 4,
  parameter int DW    = 32,
  parameter int HW    = 16,
  localparam int CW   = $clog2(NBANK + 4),
  localparam int WW   = HW + DW
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [1:0]       x_op,
  input logic [2:0]       y_op,
  input logic [1:0]       d1_op,
  input logic             mvi_en,
  input logic [1:0]       mvi_cond,
  input logic [WW-1:0]    mul_prod,
  input logic [DW-1:0]    rx_q,
  input logic [DW-1:0]    ry_q,
  input logic [HW-1:0]    ph_q,
  input logic [DW-1:0]    pl_q,
  input logic [HW-1:0]    ach_q,
  input logic [DW-1:0]    acl_q,
  input logic [NBANK-1:0] ram_we
);
  // R12
  ram_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ram_we));

  // R2
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (x_op == 2'd0 && y_op == 3'd0 && d1_op == 2'd0 && !mvi_en) |=>
      ($stable(rx_q) && $stable(ry_q) && $stable(ph_q) &&
       $stable(pl_q) && $stable(ach_q) && $stable(acl_q)));

  // R10
  mvi_never_we_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mvi_en && mvi_cond == 2'd3) |-> (ram_we == '0));

  // R10
  mvi_never_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mvi_en && mvi_cond == 2'd3) |=>
      ($stable(rx_q) && $stable(ry_q) && $stable(pl_q) && $stable(acl_q)));

  // R3
  mul_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mvi_en && x_op == 2'd2 && d1_op == 2'd0) |=> ({ph_q, pl_q} == $past(mul_prod)));

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mvi_en && y_op == 3'd2 && d1_op == 2'd0) |=> (ach_q == '0 && acl_q == '0));
endmodule

bind pbus_move_unit pbm_checker #(.NBANK(NBANK), .DW(DW), .HW(HW)) u_pbm_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .x_op       (x_op),
  .y_op       (y_op),
  .d1_op      (d1_op),
  .mvi_en     (mvi_en),
  .mvi_cond   (mvi_cond),
  .mul_prod   (mul_prod),
  .rx_q       (rx_q),
  .ry_q       (ry_q),
  .ph_q       (ph_q),
  .pl_q       (pl_q),
  .ach_q      (ach_q),
  .acl_q      (acl_q),
  .ram_we     (ram_we)
);

// File: tb/test_pbus_move_unit.sv
module test_pbus_move_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  x_op;   logic [1:0] x_src;
  logic [2:0]  y_op;   logic [1:0] y_src;
  logic [1:0]  d1_op;  logic [2:0] d1_src, d1_dst;
  logic [7:0]  d1_simm;
  logic        mvi_en; logic [1:0] mvi_cond; logic [2:0] mvi_dst;
  logic [31:0] mvi_imm;
  logic        zero_flag;
  logic [127:0] ram_rdata;
  logic [47:0] mul_prod, alu_res;
  logic [31:0] rx_q, ry_q, pl_q, acl_q, ram_wdata;
  logic [15:0] ph_q, ach_q;
  logic [3:0]  ram_we;

  int checks = 0;
  int errors = 0;
  int stepn  = 0;
  logic [31:0] m_rx = '0, m_ry = '0, m_pl = '0, m_acl = '0;
  logic [15:0] m_ph = '0, m_ach = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_move_unit i_pbus_move_unit (
    .clk(clk), .rst_n(rst_n), .x_op(x_op), .x_src(x_src), .y_op(y_op), .y_src(y_src),
    .d1_op(d1_op), .d1_src(d1_src), .d1_dst(d1_dst), .d1_simm(d1_simm),
    .mvi_en(mvi_en), .mvi_cond(mvi_cond), .mvi_dst(mvi_dst), .mvi_imm(mvi_imm),
    .zero_flag(zero_flag), .ram_rdata(ram_rdata), .mul_prod(mul_prod), .alu_res(alu_res),
    .rx_q(rx_q), .ry_q(ry_q), .ph_q(ph_q), .pl_q(pl_q), .ach_q(ach_q), .acl_q(acl_q),
    .ram_we(ram_we), .ram_wdata(ram_wdata));

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bank_of(input int b);
    return ram_rdata[b*32 +: 32];
  endfunction

  function automatic logic [31:0] src_of(input logic [2:0] c);
    case (c)
      3'd4: return m_rx;
      3'd5: return m_ry;
      3'd6: return m_pl;
      3'd7: return m_acl;
      default: return bank_of(int'(c));
    endcase
  endfunction

  task automatic set_idle();
    x_op = 0; x_src = 0; y_op = 0; y_src = 0; d1_op = 0; d1_src = 0; d1_dst = 0;
    d1_simm = 0; mvi_en = 0; mvi_cond = 0; mvi_dst = 0; mvi_imm = 0; zero_flag = 0;
  endtask

  // fields are already set; this drives the data inputs, checks strobes, then registers
  task automatic step(input string tag);
    logic        wr;
    logic [31:0] wd;
    logic [2:0]  dst;
    logic [31:0] n_rx, n_ry, n_pl, n_acl;
    logic [15:0] n_ph, n_ach;
    stepn++;
    for (int b = 0; b < NB; b++)
      ram_rdata[b*32 +: 32] = (32'(stepn) * 32'h9E37_79B9) ^ (32'(b) * 32'h1357_9BDF);
    mul_prod = {16'(stepn * 7 + 3), 32'(stepn) * 32'h0101_0103};
    alu_res  = {16'(stepn * 5 + 9), ~(32'(stepn) * 32'h0203_0405)};
    #1;
    if (mvi_en) begin
      case (mvi_cond)
        2'd0: wr = 1'b1;
        2'd1: wr = zero_flag;
        2'd2: wr = !zero_flag;
        default: wr = 1'b0;
      endcase
      wd = mvi_imm; dst = mvi_dst;
    end else begin
      wr  = (d1_op == 2'd1) || (d1_op == 2'd2);
      wd  = (d1_op == 2'd1) ? {{24{d1_simm[7]}}, d1_simm} : src_of(d1_src);
      dst = d1_dst;
    end
    // R12 strobes are due in the same cycle
    chk(tag, "ram_we", 64'(ram_we), 64'((wr && dst < 3'd4) ? (4'b1 << dst) : 4'b0));
    if (wr && dst < 3'd4) chk(tag, "ram_wdata", 64'(ram_wdata), 64'(wd));
    n_rx = m_rx; n_ry = m_ry; n_pl = m_pl; n_acl = m_acl; n_ph = m_ph; n_ach = m_ach;
    if (!mvi_en) begin
      case (x_op)
        2'd1: n_rx = bank_of(int'(x_src));
        2'd2: begin n_ph = mul_prod[47:32]; n_pl = mul_prod[31:0]; end
        2'd3: n_pl = bank_of(int'(x_src));
        default: ;
      endcase
      case (y_op)
        3'd1: n_ry = bank_of(int'(y_src));
        3'd2: begin n_ach = '0; n_acl = '0; end
        3'd3: begin n_ach = alu_res[47:32]; n_acl = alu_res[31:0]; end
        3'd4: n_acl = bank_of(int'(y_src));
        default: ;
      endcase
    end
    if (wr) case (dst)
      3'd4: n_rx = wd;
      3'd5: n_ry = wd;
      3'd6: n_pl = wd;
      3'd7: n_acl = wd;
      default: ;
    endcase
    @(posedge clk); #1;
    m_rx = n_rx; m_ry = n_ry; m_pl = n_pl; m_acl = n_acl; m_ph = n_ph; m_ach = n_ach;
    chk(tag, "rx ry", {rx_q, ry_q}, {m_rx, m_ry});
    chk(tag, "ph pl", {16'h0, ph_q, pl_q}, {16'h0, m_ph, m_pl});
    chk(tag, "ach acl", {16'h0, ach_q, acl_q}, {16'h0, m_ach, m_acl});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_idle();
    ram_rdata = '0; mul_prod = '0; alu_res = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "regs in reset", {rx_q, ry_q ^ pl_q}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after release
    chk("R1", "rx ry", {rx_q, ry_q}, 64'h0);
    chk("R1", "ph pl ach", {ph_q, pl_q, ach_q}, 64'h0);
    chk("R1", "acl we", {28'h0, ram_we, acl_q}, 64'h0);

    // R9 seed every register with distinct values
    for (int d = 4; d < 8; d++) begin
      set_idle(); mvi_en = 1; mvi_dst = 3'(d); mvi_imm = 32'hC0DE_0000 + 32'(d); step("R9");
    end
    set_idle(); x_op = 2; y_op = 3; step("R3");

    // R2 all buses idle
    for (int i = 0; i < 4; i++) begin set_idle(); step("R2"); end

    // R3 X bus sweep
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < NB; s++) begin
        set_idle(); x_op = 2'(o); x_src = 2'(s); step("R3");
      end

    // R4 Y bus sweep
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < NB; s++) begin
        set_idle(); y_op = 3'(o); y_src = 2'(s); step("R4");
        if (o == 2 || o == 3) begin set_idle(); x_op = 2; step("R4"); end
      end

    // R5 short immediate into every destination, sign extension corners
    for (int d = 0; d < 8; d++)
      for (int k = 0; k < 5; k++) begin
        set_idle(); d1_op = 1; d1_dst = 3'(d);
        case (k)
          0: d1_simm = 8'h00; 1: d1_simm = 8'h7F; 2: d1_simm = 8'h80;
          3: d1_simm = 8'hFF; default: d1_simm = 8'h5A;
        endcase
        step("R5");
      end

    // R6 every source to every destination, and the idle d1 code
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++) begin
        set_idle(); d1_op = 2; d1_src = 3'(s); d1_dst = 3'(d); step("R6");
      end
    for (int d = 0; d < 8; d++) begin
      set_idle(); d1_op = 3; d1_dst = 3'(d); d1_simm = 8'hAA; step("R6");
    end

    // R7 R8 concurrent moves on registers, D1 register-to-register
    for (int xo = 0; xo < 4; xo++)
      for (int yo = 0; yo < 8; yo++)
        for (int dop = 0; dop < 3; dop++)
          for (int s = 4; s < 8; s++)
            for (int d = 4; d < 8; d++) begin
              set_idle(); x_op = 2'(xo); x_src = 2'(s); y_op = 3'(yo); y_src = 2'(d);
              d1_op = 2'(dop); d1_src = 3'(s); d1_dst = 3'(d); d1_simm = 8'(s * 37 + d);
              step((dop == 0) ? "R7" : "R8");
            end

    // R9 R10 conditional immediate load across flag and destination
    for (int c = 0; c < 4; c++)
      for (int z = 0; z < 2; z++)
        for (int d = 0; d < 8; d++) begin
          set_idle(); mvi_en = 1; mvi_cond = 2'(c); zero_flag = z[0]; mvi_dst = 3'(d);
          mvi_imm = 32'h8000_1234 ^ 32'(c * 16 + z * 8 + d);
          step((c == 0) ? "R9" : "R10");
        end

    // R11 bus fields while load-immediate is active
    for (int xo = 0; xo < 4; xo++)
      for (int yo = 0; yo < 8; yo++) begin
        set_idle(); mvi_en = 1; mvi_cond = 3; x_op = 2'(xo); y_op = 3'(yo);
        d1_op = 2'(xo % 3); d1_src = 3'(yo); d1_dst = 3'(yo); step("R11");
        set_idle(); mvi_en = 1; mvi_cond = 0; mvi_dst = 3'(4 + xo); mvi_imm = 32'(yo * 1111);
        x_op = 2'(xo); y_op = 3'(yo); d1_op = 1; d1_dst = 3'(yo); step("R11");
      end

    // R12 strobe timing once more with a bank write followed by idle
    set_idle(); d1_op = 2; d1_src = 3'd4; d1_dst = 3'd2; step("R12");
    set_idle(); step("R12");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule